// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiplier

This block forms the 64-bit product of two 32-bit words over a series of single-cycle micro-operations chosen by a small op code. A load op clears the high half of the product pair, places the multiplier in the low half, and records whether the multiplicand is to be treated as signed. Each step op then retires two multiplier bits. The two lowest bits of the low half, together with a pending-subtract flag carried over from the previous step, are recoded into a digit of zero, one or two. The step adds or subtracts the multiplicand accordingly and moves the pair right by two bits. For a digit of two, the add sits between two single-bit shifts.

Sixteen steps after the load, the pair holds the product of the multiplicand with the multiplier read as a signed number. The adjust op adds the multiplicand to the high half once when a subtract is still pending, which turns the multiplier into an unsigned number. So an unsigned product takes load-unsigned, 16 steps and adjust. A signed product takes load-signed and 16 steps. A signed-by-unsigned product takes load-signed, 16 steps and adjust. The read op brings the low half out on the result port. The multiplicand must be presented on its input on every op of the sequence.

Top module: `booth_mul_iter`

## Requirements
- R1: After a synchronous active-low reset, result_o and err_o are 0 and all internal state is cleared, so a read op issued first returns 0.
- R2: Op code 1 (load-signed) and op code 2 (load-unsigned) clear the high half, the pending-subtract flag and the product-sign flag, load the low half from mplier_i, and drive result_o to 0 in the next cycle. Load-signed records the multiplicand sign from mcand_i bit 31. Load-unsigned records it as 0.
- R3: Op code 3 (step) recodes low-half bits [1:0] with the pending-subtract flag p. The digit is zero for 00 with p=0 or 11 with p=1. It is two for 10 with p=0 or 01 with p=1. It is one otherwise.
- R4: After every step, the pending-subtract flag equals bit 1 of the low half as it stood before that step.
- R5: A step moves the {high, low} pair right by two bits. A digit of zero adds nothing and leaves the product-sign flag unchanged. A digit of one adds the multiplicand before both shifts, and subtracts it when the new pending-subtract flag is 1. A digit of two applies the add or subtract between the first and the second shift. result_o shows the new high half in the next cycle.
- R6: The bits shifted in at the top equal the sign of the exact running product. For a non-zero multiplicand and a non-zero digit, the new product-sign flag is the new pending-subtract flag XOR the recorded multiplicand sign.
- R7: Op code 4 (adjust) adds mcand_i to the high half only when the pending-subtract flag is 1, and otherwise leaves it unchanged. result_o shows the high half in the next cycle.
- R8: Op code 5 (read) drives result_o to the low half in the next cycle and changes no other state.
- R9: After a load and 16 steps, with an adjust where one applies, the {high, low} pair equals the reference product for unsigned-by-unsigned, signed-by-signed and signed-by-unsigned operands. This includes the operands 0, 0xFFFFFFFF and 0x80000000.
- R10: Op code 0 (no-op) changes no state, leaves result_o unchanged and drives err_o to 0.
- R11: Op codes 6 and 7 are invalid. They change no state and leave result_o unchanged, and err_o is 1 in the next cycle. err_o returns to 0 after the next valid op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Micro-operation code, one per cycle |
| mcand_i | input | 32 | Multiplicand, presented on every op of a sequence |
| mplier_i | input | 32 | Multiplier, taken by the load ops |
| result_o | output | 32 | Registered result of the last op that writes a result |
| err_o | output | 1 | High for one cycle after an invalid op code |

## Verification
The product-sign property assumes that mcand_i holds the same value from the load through every step of a sequence. It also assumes that no step is issued before the first load after reset. The bench drives each multiply as a complete sequence with both operands held constant for its whole length, including the inserted no-op, invalid and read ops. Every other property relates only the op code to state one cycle later, so it holds for any op order.

// File: rtl/booth_mul_pkg.sv
// Shared types for the iterative Booth multiplier.
// Assumes a 3-bit op field; codes 6 and 7 are left unassigned and treated as invalid.
package booth_mul_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LDS  = 3'd1,
        OP_LDU  = 3'd2,
        OP_STEP = 3'd3,
        OP_ADJ  = 3'd4,
        OP_READ = 3'd5
    } mul_op_e;

    typedef enum logic [1:0] {
        DIG_ZERO = 2'd0,
        DIG_ONE  = 2'd1,
        DIG_TWO  = 2'd2
    } digit_e;

    typedef struct packed {
        logic load;
        logic load_signed;
        logic step;
        logic adjust;
        logic read;
        logic bad;
    } op_ctrl_t;

endpackage

// File: rtl/booth_op_ctrl.sv
// Decodes the micro-operation code into one control bit per action.
// Assumes op_i is valid every cycle; unassigned codes raise the bad flag only.
module booth_op_ctrl
    import booth_mul_pkg::*;
(
    input  logic [2:0] op_i,
    output op_ctrl_t   ctrl_o
);

    // Map each code to its action bits; unknown codes act on nothing.
    always_comb begin
        ctrl_o = '0;
        case (op_i)
            OP_NOP:  ctrl_o = '0;
            OP_LDS:  begin ctrl_o.load = 1'b1; ctrl_o.load_signed = 1'b1; end
            OP_LDU:  ctrl_o.load = 1'b1;
            OP_STEP: ctrl_o.step = 1'b1;
            OP_ADJ:  ctrl_o.adjust = 1'b1;
            OP_READ: ctrl_o.read = 1'b1;
            default: ctrl_o.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/booth_digit_dec.sv
// Recodes the two low multiplier bits and the pending-subtract flag into a
// Booth digit magnitude and a subtract direction.
// Assumes the flag holds the multiplier bit retired just before these two.
module booth_digit_dec
    import booth_mul_pkg::*;
(
    input  logic [1:0] pair_i,
    input  logic       pend_i,
    output digit_e     kind_o,
    output logic       neg_o
);

    // Digit value is pend + pair[0] - 2*pair[1]; keep only its magnitude class.
    always_comb begin
        if ((pair_i == 2'b00 && !pend_i) || (pair_i == 2'b11 && pend_i)) begin
            kind_o = DIG_ZERO;
        end else if ((pair_i == 2'b10 && !pend_i) || (pair_i == 2'b01 && pend_i)) begin
            kind_o = DIG_TWO;
        end else begin
            kind_o = DIG_ONE;
        end
    end

    // A negative digit comes exactly from a set upper bit; it also becomes the next flag.
    assign neg_o = pair_i[1];

endmodule

// File: rtl/booth_step_unit.sv
// One Booth step: optional pre-shift, add/subtract of the multiplicand,
// then the remaining shift so that the pair always moves two places.
// Assumes the high word with its sign flag is the exact running value scaled
// down, which fits in W+1 bits; the adder is W+2 bits wide so no sum overflows.
module booth_step_unit
    import booth_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] mq_i,
    input  logic         psign_i,
    input  logic [W-1:0] mcand_i,
    input  logic         msign_i,
    input  digit_e       kind_i,
    input  logic         neg_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] mq_o,
    output logic         psign_o
);

    localparam int XW = W + 2;

    logic [XW-1:0] x_full;
    logic [XW-1:0] x_pre;
    logic [XW-1:0] m_ext;
    logic [XW-1:0] y_sum;
    logic [W-1:0]  mq_pre;

    // Extend both operands to the wide adder using their tracked signs.
    always_comb begin
        x_full = {psign_i, psign_i, hi_i};
        m_ext  = {msign_i, msign_i, mcand_i};
    end

    // Digit two takes its first single-bit shift before the adder.
    always_comb begin
        if (kind_i == DIG_TWO) begin
            x_pre  = $signed(x_full) >>> 1;
            mq_pre = {hi_i[0], mq_i[W-1:1]};
        end else begin
            x_pre  = x_full;
            mq_pre = mq_i;
        end
    end

    // Add, subtract or pass the multiplicand according to the digit.
    always_comb begin
        if (kind_i == DIG_ZERO) begin
            y_sum = x_pre;
        end else if (neg_i) begin
            y_sum = x_pre - m_ext;
        end else begin
            y_sum = x_pre + m_ext;
        end
    end

    // Finish the move: one place after a pre-shift, two places otherwise.
    always_comb begin
        if (kind_i == DIG_TWO) begin
            hi_o = y_sum[W:1];
            mq_o = {y_sum[0], mq_pre[W-1:1]};
        end else begin
            hi_o = y_sum[W+1:2];
            mq_o = {y_sum[1:0], mq_pre[W-1:2]};
        end
        psign_o = y_sum[XW-1];
    end

endmodule

// File: rtl/booth_mul_iter.sv
// Iterative radix-4 Booth multiplier driven by one micro-operation per cycle.
// Holds the product pair, the pending-subtract flag and both sign flags.
// Assumes the sequencer issues load, W/2 steps and an optional adjust, with
// mcand_i held constant over the whole sequence.
module booth_mul_iter
    import booth_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic [W-1:0] result_o,
    output logic         err_o
);

    op_ctrl_t     ctrl;
    digit_e       dig_kind;
    logic         dig_neg;
    logic [W-1:0] hi_q, mq_q;
    logic         sub_q, msign_q, psign_q;
    logic [W-1:0] hi_step, mq_step;
    logic         psign_step;
    logic [W-1:0] hi_adj;

    booth_op_ctrl u_ctrl (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    booth_digit_dec u_dec (
        .pair_i (mq_q[1:0]),
        .pend_i (sub_q),
        .kind_o (dig_kind),
        .neg_o  (dig_neg)
    );

    booth_step_unit #(.W(W)) u_step (
        .hi_i    (hi_q),
        .mq_i    (mq_q),
        .psign_i (psign_q),
        .mcand_i (mcand_i),
        .msign_i (msign_q),
        .kind_i  (dig_kind),
        .neg_i   (dig_neg),
        .hi_o    (hi_step),
        .mq_o    (mq_step),
        .psign_o (psign_step)
    );

    // Final correction: restore the weight of a multiplier MSB read as negative.
    assign hi_adj = sub_q ? (hi_q + mcand_i) : hi_q;

    // Product pair update per op; nothing moves on a no-op or an invalid code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            mq_q <= '0;
        end else if (ctrl.load) begin
            hi_q <= '0;
            mq_q <= mplier_i;
        end else if (ctrl.step) begin
            hi_q <= hi_step;
            mq_q <= mq_step;
        end else if (ctrl.adjust) begin
            hi_q <= hi_adj;
        end
    end

    // Flag update: pending subtract and product sign move on steps, clear on loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q   <= 1'b0;
            psign_q <= 1'b0;
        end else if (ctrl.load) begin
            sub_q   <= 1'b0;
            psign_q <= 1'b0;
        end else if (ctrl.step) begin
            sub_q   <= dig_neg;
            psign_q <= psign_step;
        end
    end

    // Multiplicand sign is captured only by the load ops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msign_q <= 1'b0;
        end else if (ctrl.load) begin
            msign_q <= ctrl.load_signed & mcand_i[W-1];
        end
    end

    // Result port follows the op that produced a word; others hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else if (ctrl.load) begin
            result_o <= '0;
        end else if (ctrl.step) begin
            result_o <= hi_step;
        end else if (ctrl.adjust) begin
            result_o <= hi_adj;
        end else if (ctrl.read) begin
            result_o <= mq_q;
        end
    end

    // Error flag reports the previous cycle's op code only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else begin
            err_o <= ctrl.bad;
        end
    end

endmodule

// File: rtl/booth_mul_chk.sv
// Property checker for the iterative Booth multiplier, bound to its top.
// Assumes mcand_i is held from a load through the steps that follow it.
module booth_mul_chk
    import booth_mul_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_i,
    input logic [W-1:0] mcand_i,
    input logic [W-1:0] mplier_i,
    input logic [W-1:0] result_o,
    input logic         err_o,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] mq_q,
    input logic         sub_q,
    input logic         msign_q,
    input logic         psign_q,
    input digit_e       dig_kind
);

    p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LDS || op_i == OP_LDU) |=>
        (hi_q == '0 && !sub_q && !psign_q && result_o == '0 && mq_q == $past(mplier_i)));

    p_load_signed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LDS) |=> (msign_q == $past(mcand_i[W-1])));

    p_load_unsigned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LDU) |=> !msign_q);

    p_pend_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP) |=> (sub_q == $past(mq_q[1])));

    p_zero_keeps_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP && dig_kind == DIG_ZERO) |=> $stable(psign_q));

    p_step_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP) |=> (result_o == hi_q));

    p_sign_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP && dig_kind != DIG_ZERO && mcand_i != '0) |=>
        (psign_q == ($past(mq_q[1]) ^ msign_q)));

    p_adjust_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADJ && !sub_q) |=> ($stable(hi_q) && result_o == hi_q));

    p_adjust_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADJ && sub_q) |=> (hi_q == $past(hi_q) + $past(mcand_i)));

    p_read_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_READ) |=> (result_o == $past(mq_q) && $stable(mq_q) && $stable(hi_q)));

    p_nop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP) |=> (!err_o && $stable(result_o) && $stable(hi_q) && $stable(mq_q)
                              && $stable(sub_q) && $stable(psign_q) && $stable(msign_q)));

    p_invalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6 || op_i == 3'd7) |=> (err_o && $stable(result_o) && $stable(hi_q)
                              && $stable(mq_q) && $stable(sub_q) && $stable(psign_q)
                              && $stable(msign_q)));

endmodule

bind booth_mul_iter booth_mul_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .result_o (result_o),
    .err_o    (err_o),
    .hi_q     (hi_q),
    .mq_q     (mq_q),
    .sub_q    (sub_q),
    .msign_q  (msign_q),
    .psign_q  (psign_q),
    .dig_kind (dig_kind)
);

// File: tb/booth_mul_iter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver issues op sequences and queues the expected
// result_o/err_o for the cycle after each op; the monitor compares at negedge.
module booth_mul_iter_tb_top;
    import booth_mul_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic [31:0] result_o;
    logic        err_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [31:0] res;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    booth_mul_iter #(.W(32)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .result_o (result_o),
        .err_o    (err_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc++;

    // Monitor: pop every item whose cycle has come and compare at the ports.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            n_checks++;
            if (result_o !== it.res || err_o !== it.err) begin
                n_fail++;
                $display("FAIL %s: result_o=%h err_o=%b expected result_o=%h err_o=%b",
                         it.tag, result_o, err_o, it.res, it.err);
            end
        end
    end

    // Drive one op at a negedge; its effect is visible at the following negedge.
    task automatic issue(input logic [2:0] op, input logic [31:0] mc, input logic [31:0] mp);
        @(negedge clk);
        op_i = op;
        mcand_i = mc;
        mplier_i = mp;
    endtask

    task automatic expect_out(input logic [31:0] r, input logic e, input string tag);
        exp_t it;
        it.due = cyc + 1;
        it.res = r;
        it.err = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Exact pair after k steps: multiplicand times the low 2k multiplier bits,
    // with bit 2k-1 weighted negative, scaled into the pair above the unused bits.
    function automatic logic [63:0] pair_at(input logic signed [95:0] m,
                                            input logic [31:0] n, input int k);
        logic signed [95:0] b, v, p;
        logic [95:0] nz;
        nz = {64'b0, n};
        b = $signed(nz & ((96'd1 << (2 * k)) - 96'd1));
        if (k > 0 && n[2 * k - 1]) b = b - $signed(96'd1 << (2 * k));
        v = m * b;
        p = (v <<< (32 - 2 * k)) + $signed(nz >> (2 * k));
        return p[63:0];
    endfunction

    // mode 0: unsigned x unsigned, 1: signed x signed, 2: signed x unsigned.
    task automatic run_mul(input int mode, input logic [31:0] a, input logic [31:0] b,
                           input bit extra);
        logic signed [95:0] m_ext;
        logic [63:0] ref_p, pr;
        logic [2:0] bad_op;
        case (mode)
            0: ref_p = {32'b0, a} * {32'b0, b};
            1: ref_p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
            default: ref_p = $signed({{32{a[31]}}, a}) * $signed({32'b0, b});
        endcase
        m_ext = (mode == 0) ? $signed({64'b0, a}) : $signed({{64{a[31]}}, a});
        issue((mode == 0) ? OP_LDU : OP_LDS, a, b);
        expect_out(32'h0, 1'b0, "R2 load clears high");
        if (extra) begin
            issue(OP_READ, a, b);
            expect_out(b, 1'b0, "R8 read after load");
        end
        for (int k = 1; k <= 16; k++) begin
            pr = pair_at(m_ext, b, k);
            issue(OP_STEP, a, b);
            if (k == 16 && mode == 1)
                expect_out(ref_p[63:32], 1'b0, "R9 signed product high");
            else
                expect_out(pr[63:32], 1'b0, "R3 R5 R6 step high word");
            if (extra && k == 8) begin
                bad_op = (a[0]) ? 3'd7 : 3'd6;
                issue(bad_op, a, b);
                expect_out(pr[63:32], 1'b1, "R11 invalid op holds");
                issue(OP_NOP, a, b);
                expect_out(pr[63:32], 1'b0, "R10 no-op holds, error clears");
                issue(OP_READ, a, b);
                expect_out(pr[31:0], 1'b0, "R4 R8 mid-sequence low word");
            end
        end
        if (mode != 1) begin
            issue(OP_ADJ, a, b);
            expect_out(ref_p[63:32], 1'b0, "R7 R9 adjusted product high");
        end
        issue(OP_READ, a, b);
        expect_out(ref_p[31:0], 1'b0, "R9 product low");
    endtask

    logic [31:0] corner [5] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF};

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (result_o !== 32'h0 || err_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: result_o=%h err_o=%b expected 0 0", result_o, err_o);
        end
        rst_n = 1'b1;
        issue(OP_READ, 32'h1234_5678, 32'h9ABC_DEF0);
        expect_out(32'h0, 1'b0, "R1 read after reset");
        issue(OP_ADJ, 32'h1234_5678, 32'h0);
        expect_out(32'h0, 1'b0, "R7 adjust with no pending subtract");
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int md = 0; md < 3; md++)
                    run_mul(md, corner[i], corner[j], (i == j));
        for (int r = 0; r < 40; r++)
            for (int md = 0; md < 3; md++)
                run_mul(md, $urandom, $urandom, 1'b1);
        issue(OP_NOP, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule